// File: doc/BRIEF.md
# Serial Port Handshake Register Block

This block holds the handshake state of one asynchronous serial port. Software writes a control register that drives the terminal-ready and send-request outputs. It also writes a line-control register whose bit 6 holds the transmit line in a continuous space, which is a break. The transmit bit stream from the port's shifter passes through the block, so that the break can override it.

Four modem inputs arrive with no timing relation to the bus clock: clear-to-send, data-set-ready, ring-indicator and carrier-detect. Each one passes through a two-flop synchronizer. The synchronized value is then captured as a level and compared with its previous value to detect a change. The status register reports the four levels and a sticky change bit for each input. Reading the status register clears the change bits, unless a new change arrives in the same cycle as the read.

Access uses a simple bus with a 2-bit address, a write strobe and a read strobe. Read data is registered: it appears on the clock edge that samples the read strobe. Address map: 0 is the handshake control register, 1 is the line-control register, 2 is the status register (read only), and 3 is unused.

Top module: `modem_ctl_regs`

## Requirements
- R1: After a synchronous active-low reset, every register is zero. Both handshake outputs are low, break is off, and reads of addresses 0, 1 and 2 return 00h.
- R2: A write to address 0 sets `term_ready_o` to bit 0 of the write data and `send_req_o` to bit 1, from the next clock edge onward. A read of address 0 returns these two bits with all upper bits zero.
- R3: Address 1 stores all eight bits written to it and returns them on a read. Examples are 03h for 8 data bits, 1 stop bit and no parity, and 43h for the same format with break.
- R4: While bit 6 of the line-control register is 1, `ser_tx_out` is held low (space). While bit 6 is 0, `ser_tx_out` equals `ser_tx_in`, where high means mark.
- R5: Status bits 4, 5, 6 and 7 report the synchronized levels of clear-to-send, data-set-ready, ring-indicator and carrier-detect, in that order.
- R6: Status bits 0, 1, 2 and 3 are change flags for the same four inputs, in the same order. A flag is set on a rising or a falling change of its synchronized input and stays set until it is cleared.
- R7: A read of address 2 clears every change flag whose input did not change in that same cycle.
- R8: If a synchronized input changes in the same cycle as a status read, the read returns the old state, and the change flag is set afterwards rather than cleared.
- R9: Each modem input passes through two synchronizer flops before capture. A change applied between clock edges is therefore invisible to a read sampled at the first or second following edge, and it appears in the status register after the third edge.
- R10: Writes to address 2 or address 3 change no register. A read of address 3 returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle |
| bus_re | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 8 | Registered read data |
| cts_async_i | input | 1 | Clear-to-send, asynchronous |
| dsr_async_i | input | 1 | Data-set-ready, asynchronous |
| ri_async_i | input | 1 | Ring-indicator, asynchronous |
| dcd_async_i | input | 1 | Carrier-detect, asynchronous |
| ser_tx_in | input | 1 | Transmit bit from the shifter, high = mark |
| ser_tx_out | output | 1 | Transmit line after the break override |
| term_ready_o | output | 1 | Terminal-ready output |
| send_req_o | output | 1 | Send-request output |

## Verification
The first input pattern changes one modem input and then reads the status register on several consecutive cycles. This separates the two synchronizer cycles from the cycle in which a change meets a status read. Next, three inputs rise together and one input falls alone, which shows whether rising and falling changes both set their flag and whether each level and flag lands in its own bit position. Writes of 03h and 43h, each with the transmit input at mark and at space, show the break override apart from plain pass-through. Writes to the status address and to the unused address confirm that neither one disturbs any register.

// File: rtl/mcsr_pkg.sv
// Shared constants for the handshake register block: bus widths,
// register addresses and the bit position of the break control.
package mcsr_pkg;
    localparam int REG_AW  = 2;
    localparam int REG_DW  = 8;
    localparam int N_MODEM = 4;
    localparam int BRK_BIT = 6;

    localparam logic [REG_AW-1:0] A_HSK  = 2'd0;
    localparam logic [REG_AW-1:0] A_LINE = 2'd1;
    localparam logic [REG_AW-1:0] A_STAT = 2'd2;
endpackage

// File: rtl/mcsr_sync.sv
// Multi-stage flop synchronizer for a vector of asynchronous inputs.
// Assumes every bit is an independent slow level, so no bus coherence
// is required. All stages reset to zero.
module mcsr_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift the input through one more stage of the chain.
        always_ff @(posedge clk) begin
            if (!rst_n)      chain[s] <= '0;
            else if (s == 0) chain[s] <= async_i;
            else             chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/mcsr_delta.sv
// Level capture and sticky change flags for synchronized inputs.
// Assumes sync_i is already synchronous to clk. A change in the same
// cycle as rd_clr wins over the clear, so no change event is lost.
module mcsr_delta #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic         rd_clr,
    output logic [W-1:0] level_o,
    output logic [W-1:0] delta_o
);
    logic [W-1:0] chg;

    assign chg = sync_i ^ level_o;

    for (genvar g = 0; g < W; g++) begin : g_bit
        // Capture the level and update the sticky change flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                level_o[g] <= 1'b0;
                delta_o[g] <= 1'b0;
            end else begin
                level_o[g] <= sync_i[g];
                delta_o[g] <= chg[g] | (delta_o[g] & ~rd_clr);
            end
        end

        // R5
        level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> level_o[g] == $past(sync_i[g]));
        // R6
        edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            chg[g] |=> delta_o[g]);
        // R7
        rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr && !chg[g]) |=> !delta_o[g]);
        // R8
        rd_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr && chg[g]) |=> delta_o[g]);
    end
endmodule

// File: rtl/modem_ctl_regs.sv
// Handshake register block of a serial port: control outputs, a break
// override on the transmit line, and synchronized modem status with
// sticky change flags. Assumes single-cycle bus strobes. Read data is
// registered, and a status read clears the change flags.
module modem_ctl_regs
    import mcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [REG_DW-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [REG_DW-1:0] bus_rdata,
    input  logic              cts_async_i,
    input  logic              dsr_async_i,
    input  logic              ri_async_i,
    input  logic              dcd_async_i,
    input  logic              ser_tx_in,
    output logic              ser_tx_out,
    output logic              term_ready_o,
    output logic              send_req_o
);
    logic [1:0]         hsk_q;
    logic [REG_DW-1:0]  line_q;
    logic [N_MODEM-1:0] raw_in, sync_in, lvl, dlt;
    logic [REG_DW-1:0]  rd_mux;
    logic               stat_rd;

    assign raw_in  = {dcd_async_i, ri_async_i, dsr_async_i, cts_async_i};
    assign stat_rd = bus_re && (bus_addr == A_STAT);

    mcsr_sync #(.W(N_MODEM), .STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(sync_in)
    );

    mcsr_delta #(.W(N_MODEM)) delta_i (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_in), .rd_clr(stat_rd),
        .level_o(lvl), .delta_o(dlt)
    );

    // Register writes to the control and line-control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsk_q  <= '0;
            line_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_HSK)  hsk_q  <= bus_wdata[1:0];
            if (bus_addr == A_LINE) line_q <= bus_wdata;
        end
    end

    // Select read data by address.
    always_comb begin
        unique case (bus_addr)
            A_HSK:   rd_mux = {{(REG_DW-2){1'b0}}, hsk_q};
            A_LINE:  rd_mux = line_q;
            A_STAT:  rd_mux = {lvl, dlt};
            default: rd_mux = '0;
        endcase
    end

    // Register read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
    end

    assign term_ready_o = hsk_q[0];
    assign send_req_o   = hsk_q[1];
    assign ser_tx_out   = ser_tx_in & ~line_q[BRK_BIT];

    // R2
    hsk_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_HSK) |=>
            (term_ready_o == $past(bus_wdata[0]) && send_req_o == $past(bus_wdata[1])));
    // R4
    brk_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_q[BRK_BIT] |-> !ser_tx_out);
    // R10
    ro_wr_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[1]) |=> ($stable(line_q) && $stable(hsk_q)));
endmodule

// File: tb/modem_ctl_regs_tb_top.sv
// Scoreboard bench: the read driver queues expected bytes and the
// monitor pops and compares them when the registered data is valid.
module modem_ctl_regs_tb_top;
    localparam time CLK_T = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic       cts = 1'b0, dsr = 1'b0, ri = 1'b0, dcd = 1'b0;
    logic       tx_in = 1'b1;
    logic       tx_out, term_rdy, send_rq;

    int n_chk = 0, n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       rd_evt;

    always #(CLK_T/2) clk = ~clk;

    modem_ctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .cts_async_i(cts), .dsr_async_i(dsr), .ri_async_i(ri), .dcd_async_i(dcd),
        .ser_tx_in(tx_in), .ser_tx_out(tx_out),
        .term_ready_o(term_rdy), .send_req_o(send_rq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected byte for each completed read.
    always @(rd_evt) begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end

    // Drivers start and end on a falling edge.
    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        -> rd_evt;
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_T * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 term_ready", {7'd0, term_rdy}, 8'h00);
        check("R1 send_req", {7'd0, send_rq}, 8'h00);
        check("R1 tx pass", {7'd0, tx_out}, 8'h01);
        rd(2'd0, 8'h00, "R1 ctrl");
        rd(2'd1, 8'h00, "R1 line");
        rd(2'd2, 8'h00, "R1 status");

        // R2 handshake outputs
        wr(2'd0, 8'hFF);
        check("R2 term after FF", {7'd0, term_rdy}, 8'h01);
        check("R2 send after FF", {7'd0, send_rq}, 8'h01);
        rd(2'd0, 8'h03, "R2 ctrl readback");
        wr(2'd0, 8'h02);
        check("R2 term after 02", {7'd0, term_rdy}, 8'h00);
        check("R2 send after 02", {7'd0, send_rq}, 8'h01);
        wr(2'd0, 8'h01);
        check("R2 term after 01", {7'd0, term_rdy}, 8'h01);
        check("R2 send after 01", {7'd0, send_rq}, 8'h00);

        // R3 R4 line control and break
        wr(2'd1, 8'h03);
        rd(2'd1, 8'h03, "R3 line 03");
        check("R4 mark passes", {7'd0, tx_out}, 8'h01);
        tx_in = 1'b0; #1;
        check("R4 space passes", {7'd0, tx_out}, 8'h00);
        tx_in = 1'b1;
        wr(2'd1, 8'h43);
        rd(2'd1, 8'h43, "R3 line 43");
        check("R4 break forces space", {7'd0, tx_out}, 8'h00);
        wr(2'd1, 8'h03);
        check("R4 break released", {7'd0, tx_out}, 8'h01);

        // R9 synchronizer latency, R8 race with read, R5 R6 R7
        cts = 1'b1;
        rd(2'd2, 8'h00, "R9 edge 1");
        rd(2'd2, 8'h00, "R9 edge 2");
        rd(2'd2, 8'h00, "R8 read meets change");
        rd(2'd2, 8'h11, "R8 flag kept, R5 cts level");
        rd(2'd2, 8'h10, "R7 flag cleared");

        // R6 rising changes on three inputs, R5 bit order
        dsr = 1'b1; ri = 1'b1; dcd = 1'b1;
        idle(4);
        rd(2'd2, 8'hFE, "R6 three rising");
        rd(2'd2, 8'hF0, "R7 cleared again");
        cts = 1'b0;
        idle(4);
        rd(2'd2, 8'hE1, "R6 falling cts");
        dcd = 1'b0;
        idle(4);
        rd(2'd2, 8'h68, "R6 falling dcd bit order");
        rd(2'd2, 8'h60, "R7 cleared dcd");

        // R10 read-only and unused addresses
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFF);
        rd(2'd2, 8'h60, "R10 status unchanged");
        rd(2'd0, 8'h01, "R10 ctrl unchanged");
        rd(2'd1, 8'h03, "R10 line unchanged");
        rd(2'd3, 8'h00, "R10 unused reads zero");

        // R1 reset during operation
        dsr = 1'b0; ri = 1'b0;
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h43);
        idle(3);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        check("R1 term after reset", {7'd0, term_rdy}, 8'h00);
        check("R1 send after reset", {7'd0, send_rq}, 8'h00);
        check("R1 break off after reset", {7'd0, tx_out}, 8'h01);
        rd(2'd1, 8'h00, "R1 line after reset");
        rd(2'd2, 8'h00, "R1 status after reset");

        idle(2);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule